// File: doc/BRIEF.md
# Byte and Word Transmit FIFO

This block is the transmit queue in front of a serial sequencer. Software fills it through two push ports. The byte port stores one byte per write. The word port stores a 32-bit word as four bytes, least significant byte first. All bytes land in one byte-granular circular store. The sequencer takes one byte per request from the head.

The block reports the free space in bytes through a transfer status word, so that software knows how much it may still write. It also raises three flags in an interrupt status word:

- a sticky empty flag, set when the occupancy drops to zero;
- a live full flag;
- a sticky overrun flag, which also drives an error interrupt line.

A word push is all-or-nothing. Either all four bytes are stored, or none are and overrun is raised. Both ports may push in the same cycle. In that case the byte port's byte is queued ahead of the word's bytes.

Top module: `txq_byteword_fifo`

## Requirements
- R1: After reset the free space equals DEPTH, the empty flag (irq_status bit 9) is 1, the full flag (bit 10) and overrun flag (bit 11) are 0, and pop_valid is 0.
- R2: A byte-port write with free space of at least one stores byte_wdata as one entry at the tail of the queue.
- R3: A word-port write stores four entries: bits 7:0 first, then 15:8, then 23:16, and bits 31:24 last.
- R4: Bytes leave in the order they were stored. When both ports write in one cycle, the byte-port byte is queued ahead of the word's four bytes.
- R5: xfer_status bits 31:16 hold the free space in bytes (DEPTH minus occupancy), and bits 15:0 are zero. The value reflects a push or pop from the cycle after the clock edge that performs it.
- R6: A word push is stored only if the free space is at least four plus one more when the byte port is accepted in the same cycle. Otherwise none of its bytes are stored and overrun is set.
- R7: A byte push when the free space is zero stores nothing and sets overrun.
- R8: The full flag (irq_status bit 10) is 1 exactly when the occupancy equals DEPTH.
- R9: The empty flag (irq_status bit 9) is sticky. It is set by a clock edge that takes the occupancy from non-zero to zero, and cleared by clr_empty. A set in the same cycle as a clear wins.
- R10: The overrun flag (irq_status bit 11) is sticky until clr_ovr, and a new overrun in the same cycle as a clear wins. err_irq always equals that flag.
- R11: pop_valid is 1 exactly when the queue holds at least one byte. A pop_req while the queue is empty changes nothing.
- R12: A pop and pushes in the same cycle both take effect, and the free space changes by the net byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_wr | input | 1 | Byte-port push strobe |
| byte_wdata | input | 8 | Byte to push |
| word_wr | input | 1 | Word-port push strobe |
| word_wdata | input | 32 | Word to push, least significant byte first |
| pop_req | input | 1 | Sequencer takes the head byte this cycle |
| pop_valid | output | 1 | Queue holds at least one byte |
| pop_data | output | 8 | Byte at the head of the queue |
| clr_empty | input | 1 | Clear the sticky empty flag |
| clr_ovr | input | 1 | Clear the sticky overrun flag |
| xfer_status | output | 32 | Free space in bytes in bits 31:16 |
| irq_status | output | 32 | Empty bit 9, full bit 10, overrun bit 11 |
| err_irq | output | 1 | Error interrupt, mirrors overrun |

## Verification
`pop_valid` and `pop_data` come straight from registered state. They are therefore checked in the same cycle as the pop request: the bench drives on the falling edge and samples 1 ns later, before the edge that consumes the byte.

The free space, the full flag and both sticky flags change at the first rising edge after the stimulus. The bench samples them 2 ns after that edge and compares them with a byte-queue model.

Directed phases cover ordering, dropped pushes at the full and nearly-full boundaries, and set-versus-clear collisions. A long pseudo-random sweep at a 16-byte depth then visits every occupancy level with every mix of pushes, pops and clears.

// File: rtl/txq_pkg.sv
// Package: shared constants and types for the byte/word transmit FIFO.
// Assumes: a word is four bytes; status bit positions are fixed by the
// register map that decodes them.
package txq_pkg;
    localparam int WORD_BYTES = 4;
    localparam int LANES      = WORD_BYTES + 1;   // one byte lane plus one word
    localparam int BIT_EMPTY  = 9;
    localparam int BIT_FULL   = 10;
    localparam int BIT_OVR    = 11;
    localparam int FREE_LSB   = 16;

    typedef logic [7:0] txq_byte_t;
endpackage

// File: rtl/txq_admit.sv
// Module: txq_admit
// Decides which pushes fit in the current free space and lays the accepted
// bytes out on contiguous write lanes starting at lane 0.
// Assumes: free is the registered free space; pops in the same cycle do not
// add room for pushes.
module txq_admit
    import txq_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_wr,
    input  logic [7:0]                 byte_wdata,
    input  logic                       word_wr,
    input  logic [31:0]                word_wdata,
    input  logic [CW-1:0]              free,
    output logic [LANES-1:0]           lane_we,
    output logic [LANES-1:0][7:0]      lane_data,
    output logic [2:0]                 push_cnt,
    output logic                       drop
);
    localparam logic [CW-1:0] WORD_NEED = CW'(WORD_BYTES);

    logic byte_acc;
    logic word_acc;

    // Accept decisions: byte first, then word with the byte's space removed.
    always_comb begin
        byte_acc = byte_wr && (free != '0);
        word_acc = word_wr && (free >= (WORD_NEED + CW'(byte_acc)));
        drop     = (byte_wr && !byte_acc) || (word_wr && !word_acc);
    end

    // Lane layout: byte on lane 0, word bytes after it, LSB first.
    always_comb begin
        lane_we   = '0;
        lane_data = '0;
        if (byte_acc) begin
            lane_we[0]   = 1'b1;
            lane_data[0] = byte_wdata;
        end
        if (word_acc) begin
            for (int j = 0; j < WORD_BYTES; j++) begin
                lane_we[j + int'(byte_acc)]   = 1'b1;
                lane_data[j + int'(byte_acc)] = word_wdata[8*j +: 8];
            end
        end
    end

    // Byte count written this cycle.
    always_comb begin
        push_cnt = 3'($countones(lane_we));
    end

    // R6
    word_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && (free < WORD_NEED)) |-> (drop && ($countones(lane_we) <= 1)));

    // R7
    byte_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && (free == '0)) |-> (drop && (lane_we == '0)));
endmodule

// File: rtl/txq_store.sv
// Module: txq_store
// Circular byte store with a write pointer advanced by the number of lanes
// written and a read pointer advanced by one per accepted pop.
// Assumes: DEPTH is a power of two; the lanes written are contiguous from
// lane 0; the caller never writes more than the free space.
module txq_store
    import txq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0]      lane_we,
    input  logic [LANES-1:0][7:0] lane_data,
    input  logic [2:0]            push_cnt,
    input  logic                  pop_acc,
    output txq_byte_t             head_data
);
    txq_byte_t       mem [DEPTH];
    logic [AW-1:0]   wptr;
    logic [AW-1:0]   rptr;

    // Pointer update: write pointer by the push count, read pointer by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            wptr <= wptr + AW'(push_cnt);
            if (pop_acc) begin
                rptr <= rptr + 1'b1;
            end
        end
    end

    // Data write: each active lane stores at its offset from the tail.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (lane_we[i]) begin
                mem[wptr + AW'(i)] <= lane_data[i];
            end
        end
    end

    // Head byte presented to the sequencer.
    always_comb begin
        head_data = mem[rptr];
    end
endmodule

// File: rtl/txq_level.sv
// Module: txq_level
// Tracks occupancy, derives free space and full, accepts pops only when
// non-empty, and flags the edge that drains the queue to zero.
// Assumes: push_cnt never exceeds the free space.
module txq_level #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    push_cnt,
    input  logic          pop_req,
    output logic          pop_acc,
    output logic [CW-1:0] free,
    output logic          full,
    output logic          nonempty,
    output logic          drain_evt
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CW-1:0] count;
    logic [CW-1:0] count_next;

    // Next occupancy from pushes and an accepted pop.
    always_comb begin
        pop_acc    = pop_req && (count != '0);
        count_next = count + CW'(push_cnt) - CW'(pop_acc);
        drain_evt  = (count != '0) && (count_next == '0);
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count_next;
        end
    end

    // Derived level outputs.
    always_comb begin
        free     = DEPTH_C - count;
        full     = (count == DEPTH_C);
        nonempty = (count != '0);
    end

    // R11
    pop_empty_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && (count == '0) && (push_cnt == 3'd0)) |=> (count == '0));

    // R12
    push_pop_net_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && (count != '0) && (push_cnt == 3'd1)) |=> $stable(count));

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);
endmodule

// File: rtl/txq_flags.sv
// Module: txq_flags
// Sticky empty and overrun flags; a set event in the same cycle as a clear
// takes priority.
// Assumes: events are single-cycle qualifiers from the level and admit logic.
module txq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic drain_evt,
    input  logic drop,
    input  logic clr_empty,
    input  logic clr_ovr,
    output logic empty_q,
    output logic ovr_q
);
    // Sticky flag registers; empty comes out of reset set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            ovr_q   <= 1'b0;
        end else begin
            empty_q <= (empty_q && !clr_empty) || drain_evt;
            ovr_q   <= (ovr_q && !clr_ovr) || drop;
        end
    end

    // R9
    empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_evt |=> empty_q);

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clr_ovr) |=> ovr_q);

    // R10
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovr_q);
endmodule

// File: rtl/txq_byteword_fifo.sv
// Module: txq_byteword_fifo
// Transmit FIFO with a byte push port and a word push port feeding one
// byte-granular store, popped one byte per request by the serial sequencer.
// Publishes free space in bytes and empty/full/overrun flags.
// Assumes: DEPTH is a power of two between 8 and 32768.
module txq_byteword_fifo
    import txq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_wr,
    input  logic [7:0]  byte_wdata,
    input  logic        word_wr,
    input  logic [31:0] word_wdata,
    input  logic        pop_req,
    output logic        pop_valid,
    output logic [7:0]  pop_data,
    input  logic        clr_empty,
    input  logic        clr_ovr,
    output logic [31:0] xfer_status,
    output logic [31:0] irq_status,
    output logic        err_irq
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [LANES-1:0]      lane_we;
    logic [LANES-1:0][7:0] lane_data;
    logic [2:0]            push_cnt;
    logic                  drop;
    logic                  pop_acc;
    logic [CW-1:0]         free;
    logic                  full;
    logic                  nonempty;
    logic                  drain_evt;
    logic                  empty_q;
    logic                  ovr_q;
    txq_byte_t             head_data;

    txq_admit #(.CW(CW)) u_admit (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_wr    (byte_wr),
        .byte_wdata (byte_wdata),
        .word_wr    (word_wr),
        .word_wdata (word_wdata),
        .free       (free),
        .lane_we    (lane_we),
        .lane_data  (lane_data),
        .push_cnt   (push_cnt),
        .drop       (drop)
    );

    txq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_we    (lane_we),
        .lane_data  (lane_data),
        .push_cnt   (push_cnt),
        .pop_acc    (pop_acc),
        .head_data  (head_data)
    );

    txq_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_cnt   (push_cnt),
        .pop_req    (pop_req),
        .pop_acc    (pop_acc),
        .free       (free),
        .full       (full),
        .nonempty   (nonempty),
        .drain_evt  (drain_evt)
    );

    txq_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .drain_evt  (drain_evt),
        .drop       (drop),
        .clr_empty  (clr_empty),
        .clr_ovr    (clr_ovr),
        .empty_q    (empty_q),
        .ovr_q      (ovr_q)
    );

    // Pop side and status word assembly.
    always_comb begin
        pop_valid   = nonempty;
        pop_data    = head_data;
        xfer_status = '0;
        xfer_status[FREE_LSB +: 16] = 16'(free);
        irq_status  = '0;
        irq_status[BIT_EMPTY] = empty_q;
        irq_status[BIT_FULL]  = full;
        irq_status[BIT_OVR]   = ovr_q;
        err_irq     = ovr_q;
    end

    // R8
    full_no_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_status[BIT_FULL] |-> (pop_valid && (xfer_status[31:16] == 16'd0)));
endmodule

// File: tb/tb_txq_byteword_fifo.sv
module tb_txq_byteword_fifo;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_wr = 1'b0;
    logic [7:0]  byte_wdata = '0;
    logic        word_wr = 1'b0;
    logic [31:0] word_wdata = '0;
    logic        pop_req = 1'b0;
    logic        pop_valid;
    logic [7:0]  pop_data;
    logic        clr_empty = 1'b0;
    logic        clr_ovr = 1'b0;
    logic [31:0] xfer_status;
    logic [31:0] irq_status;
    logic        err_irq;

    int checks = 0;
    int errors = 0;

    logic [7:0] mq[$];
    logic       m_empty;
    logic       m_ovr;

    txq_byteword_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .byte_wr(byte_wr), .byte_wdata(byte_wdata),
        .word_wr(word_wr), .word_wdata(word_wdata),
        .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
        .clr_empty(clr_empty), .clr_ovr(clr_ovr),
        .xfer_status(xfer_status), .irq_status(irq_status), .err_irq(err_irq)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_status(input string tag);
        logic [31:0] exp_x;
        exp_x = {16'(DEPTH - mq.size()), 16'h0};
        chk(xfer_status == exp_x, {tag, " R5 free"}, xfer_status, exp_x);
        chk(irq_status[10] == (mq.size() == DEPTH), {tag, " R8 full"},
            32'(irq_status[10]), 32'(mq.size() == DEPTH));
        chk(irq_status[9] == m_empty, {tag, " R9 empty"}, 32'(irq_status[9]), 32'(m_empty));
        chk(irq_status[11] == m_ovr, {tag, " R10 ovr"}, 32'(irq_status[11]), 32'(m_ovr));
        chk(err_irq == m_ovr, {tag, " R10 err_irq"}, 32'(err_irq), 32'(m_ovr));
    endtask

    // One cycle of stimulus: drive at falling edge, check head, update model
    // at the rising edge, check registered status 2 ns later.
    task automatic step(input string tag, input logic bw, input logic [7:0] bd,
                        input logic ww, input logic [31:0] wd, input logic pr,
                        input logic ce, input logic co);
        int  fr;
        logic bacc, wacc, pacc, was_nz;
        @(negedge clk);
        byte_wr = bw; byte_wdata = bd; word_wr = ww; word_wdata = wd;
        pop_req = pr; clr_empty = ce; clr_ovr = co;
        #1;
        chk(pop_valid == (mq.size() != 0), {tag, " R11 pop_valid"},
            32'(pop_valid), 32'(mq.size() != 0));
        if (pr && mq.size() != 0)
            chk(pop_data == mq[0], {tag, " R4 head"}, 32'(pop_data), 32'(mq[0]));
        fr     = DEPTH - mq.size();
        bacc   = bw && (fr >= 1);
        wacc   = ww && (fr >= 4 + int'(bacc));
        pacc   = pr && (mq.size() != 0);
        was_nz = (mq.size() != 0);
        @(posedge clk);
        #2;
        if (pacc) void'(mq.pop_front());
        if (bacc) mq.push_back(bd);
        if (wacc) for (int j = 0; j < 4; j++) mq.push_back(wd[8*j +: 8]);
        m_ovr   = (m_ovr && !co) || (bw && !bacc) || (ww && !wacc);
        m_empty = (m_empty && !ce) || (was_nz && mq.size() == 0);
        check_status(tag);
        byte_wr = 1'b0; word_wr = 1'b0; pop_req = 1'b0;
        clr_empty = 1'b0; clr_ovr = 1'b0;
    endtask

    initial begin
        #1_200_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        m_empty = 1'b1;
        m_ovr   = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2;
        // R1 reset state
        chk(xfer_status == {16'(DEPTH), 16'h0}, "R1 free", xfer_status, {16'(DEPTH), 16'h0});
        chk(irq_status == 32'h200, "R1 flags", irq_status, 32'h200);
        chk(pop_valid == 1'b0, "R1 pop_valid", 32'(pop_valid), 0);

        // R2 byte pushes
        step("R2", 1, 8'hA5, 0, 0, 0, 0, 0);
        step("R2", 1, 8'h3C, 0, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 0, 1, 0, 0);
        step("R2", 0, 0, 0, 0, 1, 0, 0);
        // R3 word LSB first
        step("R3", 0, 0, 1, 32'h44332211, 0, 1, 0);
        for (int k = 0; k < 4; k++) step("R3", 0, 0, 0, 0, 1, 0, 0);
        // R4 same-cycle order
        step("R4", 1, 8'h77, 1, 32'hDDCCBBAA, 0, 1, 0);
        for (int k = 0; k < 5; k++) step("R4", 0, 0, 0, 0, 1, 0, 0);
        // R8 fill to full, R6 word drop, R7 byte drop
        for (int k = 0; k < 4; k++) step("R8", 0, 0, 1, 32'h10203040 + k, 0, 0, 0);
        step("R6", 0, 0, 1, 32'hDEADBEEF, 0, 0, 0);
        step("R10", 0, 0, 0, 0, 0, 0, 1);
        step("R7", 1, 8'hEE, 0, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 0, 0, 0, 1);
        step("R6", 0, 0, 0, 0, 1, 0, 0);
        step("R6", 0, 0, 0, 0, 1, 0, 0);
        step("R6", 0, 0, 1, 32'h0BADF00D, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 1, 0, 1);
        step("R6", 0, 0, 0, 0, 1, 0, 0);
        step("R6", 1, 8'h5A, 1, 32'hCAFEF00D, 0, 0, 0);
        step("R10", 1, 8'h11, 0, 0, 0, 0, 1);
        step("R10", 0, 0, 0, 0, 0, 0, 1);
        // R9 drain sets empty; clear and set collide on the last pop
        step("R9", 0, 0, 0, 0, 0, 1, 0);
        while (mq.size() > 1) step("R9", 0, 0, 0, 0, 1, 0, 0);
        step("R9", 0, 0, 0, 0, 1, 1, 0);
        step("R9", 0, 0, 0, 0, 0, 1, 0);
        // R11 pop on empty
        step("R11", 0, 0, 0, 0, 1, 0, 0);
        step("R11", 0, 0, 0, 0, 1, 0, 0);
        // R12 push and pop together
        step("R12", 1, 8'h01, 0, 0, 0, 0, 0);
        step("R12", 1, 8'h02, 0, 0, 1, 0, 0);
        step("R12", 0, 0, 1, 32'h08070605, 1, 0, 0);
        // Pseudo-random sweep
        lf = 32'hACE1_2345;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step("R4 sweep", lf[0] & lf[1], lf[15:8], lf[2] & lf[3],
                 {lf[31:16], lf[15:0] ^ 16'h5A5A}, lf[4] | lf[5],
                 lf[6] & lf[7] & lf[8], lf[9] & lf[10] & lf[11]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule